// File: doc/BRIEF.md
# Asynchronous Serial Port with Baud Divisor, Error Flags and Flow Control

This block is a full-duplex asynchronous serial port for a processor bus. A 16-bit divisor sets how many clock cycles make one sample tick, and sixteen ticks make one bit time. A divisor of one gives the fastest rate, one bit per sixteen clocks. A divisor of zero freezes both directions.

Each character has one start bit, seven or eight data bits sent least significant bit first, an optional even or odd parity bit, and one stop bit. The receiver has a single holding register. It reports parity, framing and overrun errors, and it detects a break, meaning a line held low through a whole frame. When handshaking is enabled, the transmitter starts a frame only while the clear-to-send input is low. The request-to-send output is driven high while the receive holding register holds an unread character.

Software uses four word registers, selected by `bus_addr`:
- 0: data. A write loads the transmit holding register. A read returns the received character and marks it consumed.
- 1: status.
- 2: control.
- 3: divisor.

Top module: `uart_port`

## Requirements
- R1: After reset `txd` is 1, `rts_n` is 0, the divisor reads 0, and status reads 0x0002. The status bits are: bit0 receive full, bit1 transmit holding empty, bit2 parity error, bit3 framing error, bit4 overrun, bit5 break, bit6 transmitter busy.
- R2: One bit lasts 16 x divisor clock cycles. With divisor 3, a start bit followed by a data bit of value 1 keeps `txd` low for exactly 48 cycles.
- R3: While the divisor is 0, `txd` stays 1, a written character waits in the holding register, and frames on `rxd` are not received. Writing a non-zero divisor lets the pending character go out.
- R4: A transmitted frame is a low start bit, then the data bits least significant first, then the parity bit when enabled, then one high stop bit. Control bit0 selects 8 data bits when set and 7 when clear.
- R5: Control bit1 enables parity. Control bit2 selects odd parity when set and even parity when clear. The parity bit makes the number of ones in the data plus the parity bit even or odd, as selected.
- R6: A received character sets status bit0 and reads back from register 0. That read clears status bit0.
- R7: A received parity bit that does not match the configured parity sets status bit2.
- R8: A stop bit sampled low sets status bit3.
- R9: When a character completes while status bit0 is still set, status bit4 is set, the new character is dropped, and the earlier character stays readable.
- R10: A line held low through the stop bit position of a frame sets status bit5 once. The receiver then waits for the line to return high before it looks for a new start bit.
- R11: A low pulse on `rxd` that ends before the middle of the start bit does not start a character.
- R12: With control bit3 set, no frame starts while `cts_n` is 1, and `rts_n` equals status bit0. With control bit3 clear, `rts_n` is 0.
- R13: A read of the status register clears bits 2 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 divisor |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; its side effects take place at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
The assertions assume several things about the inputs:
- The control register does not change while a frame is being sent or received.
- A read strobe lasts a single cycle per access.
- `rxd` changes only at bit boundaries set by the same divisor the receiver uses.

The stimulus keeps to these assumptions:
- Control and divisor writes are made only while both serial directions are idle.
- Every register access is one strobe cycle.
- Serial frames are driven with bit times that are exact multiples of the programmed divisor, except for the deliberate glitch and the long break.

// File: rtl/uart_port.sv
module uart_port #(
  parameter int DIV_W = 16,
  parameter int DW    = 16,
  parameter int OSR   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rxd,
  output logic          txd,
  input  logic          cts_n,
  output logic          rts_n
);
  localparam int PW  = $clog2(OSR);
  localparam int MID = OSR/2 - 1;
  localparam int FW  = 11;

  logic [DIV_W-1:0] div, dcnt;
  logic [3:0] ctrl;
  logic tick, halt;

  wire len8   = ctrl[0];
  wire par_en = ctrl[1];
  wire par_od = ctrl[2];
  wire hs_en  = ctrl[3];

  wire wr_data = bus_wr && bus_addr == 2'd0;
  wire wr_ctrl = bus_wr && bus_addr == 2'd2;
  wire wr_div  = bus_wr && bus_addr == 2'd3;
  wire rd_data = bus_rd && bus_addr == 2'd0;
  wire rd_stat = bus_rd && bus_addr == 2'd1;

  wire [3:0] nbits = 4'd9 + {3'b0, len8} + {3'b0, par_en};
  wire [3:0] last_data = len8 ? 4'd8 : 4'd7;

  assign halt = (div == '0);
  assign tick = !halt && (dcnt == div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div <= '0; ctrl <= '0; dcnt <= '0;
    end else begin
      if (wr_div)  div  <= bus_wdata[DIV_W-1:0];
      if (wr_ctrl) ctrl <= bus_wdata[3:0];
      if (wr_div || halt || tick) dcnt <= '0;
      else                        dcnt <= dcnt + DIV_W'(1);
    end

  // transmitter
  logic [7:0] thr;
  logic thr_full, tx_busy;
  logic [FW-1:0] tsh, tframe;
  logic [3:0] tleft;
  logic [PW-1:0] tph;

  wire [7:0] tdat = len8 ? thr : {1'b0, thr[6:0]};
  wire tpar = (^tdat) ^ par_od;
  wire tx_go = tick && !tx_busy && thr_full && !(hs_en && cts_n);

  always_comb begin
    tframe = '1;
    tframe[0] = 1'b0;
    if (len8) begin
      tframe[8:1] = thr;
      if (par_en) tframe[9] = tpar;
    end else begin
      tframe[7:1] = thr[6:0];
      if (par_en) tframe[8] = tpar;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      thr <= '0; thr_full <= 1'b0; tx_busy <= 1'b0;
      tsh <= '1; tleft <= '0; tph <= '0;
    end else begin
      if (halt) begin
        tx_busy <= 1'b0; tph <= '0;
      end else if (tx_go) begin
        tsh <= tframe; tleft <= nbits; tph <= '0;
        tx_busy <= 1'b1; thr_full <= 1'b0;
      end else if (tx_busy && tick) begin
        tph <= tph + PW'(1);
        if (tph == PW'(OSR-1)) begin
          tsh   <= {1'b1, tsh[FW-1:1]};
          tleft <= tleft - 4'd1;
          if (tleft == 4'd1) tx_busy <= 1'b0;
        end
      end
      if (wr_data) begin
        thr <= bus_wdata[7:0]; thr_full <= 1'b1;
      end
    end

  assign txd = tx_busy ? tsh[0] : 1'b1;

  // receiver
  logic rs1, rs2;
  logic rx_act, rx_wait, zero, rpar;
  logic [PW-1:0] rph;
  logic [3:0] ridx;
  logic [7:0] rbuf, rbr;
  logic rx_full, perr, ferr, ovr, brk;

  wire rexp = (^rbuf) ^ par_od;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs1 <= 1'b1; rs2 <= 1'b1;
    end else begin
      rs1 <= rxd; rs2 <= rs1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_act <= 1'b0; rx_wait <= 1'b0; zero <= 1'b0; rpar <= 1'b0;
      rph <= '0; ridx <= '0; rbuf <= '0; rbr <= '0;
      rx_full <= 1'b0; perr <= 1'b0; ferr <= 1'b0; ovr <= 1'b0; brk <= 1'b0;
    end else begin
      if (rd_data) rx_full <= 1'b0;
      if (rd_stat) begin
        perr <= 1'b0; ferr <= 1'b0; ovr <= 1'b0; brk <= 1'b0;
      end
      if (halt) begin
        rx_act <= 1'b0; rx_wait <= 1'b0;
      end else if (tick) begin
        if (!rx_act) begin
          if (rx_wait) begin
            if (rs2) rx_wait <= 1'b0;
          end else if (!rs2) begin
            rx_act <= 1'b1; rph <= '0; ridx <= '0; zero <= 1'b1; rbuf <= '0;
          end
        end else begin
          rph <= rph + PW'(1);
          if (rph == PW'(MID)) begin
            ridx <= ridx + 4'd1;
            if (rs2) zero <= 1'b0;
            if (ridx == 4'd0) begin
              if (rs2) rx_act <= 1'b0;
            end else if (ridx == nbits - 4'd1) begin
              rx_act <= 1'b0;
              if (!rs2) rx_wait <= 1'b1;
              if (zero && !rs2) brk <= 1'b1;
              if (rx_full && !rd_data) ovr <= 1'b1;
              else begin
                rbr <= rbuf; rx_full <= 1'b1;
                if (par_en && rpar != rexp) perr <= 1'b1;
                if (!rs2) ferr <= 1'b1;
              end
            end else if (ridx <= last_data) begin
              rbuf[3'(ridx - 4'd1)] <= rs2;
            end else begin
              rpar <= rs2;
            end
          end
        end
      end
    end

  assign rts_n = hs_en & rx_full;

  wire [6:0] status = {tx_busy, brk, ovr, ferr, perr, !thr_full, rx_full};

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = {{(DW-8){1'b0}}, rbr};
      2'd1:    bus_rdata = {{(DW-7){1'b0}}, status};
      2'd2:    bus_rdata = {{(DW-4){1'b0}}, ctrl};
      default: bus_rdata = DW'(div);
    endcase

  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && div > DIV_W'(1) && !wr_div |=> !tick);
  a_r3_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> txd);
  a_r3_rx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !$rose(rx_full));
  a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
  a_r12_cts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en && cts_n && !tx_busy |=> !tx_busy);
  a_r9_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !rd_data |=> $stable(rbr) && rx_full);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && rx_full |=> !rx_full);
endmodule

// File: tb/uart_port_bench.sv
module uart_port_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic rxd = 1'b1, txd, cts_n = 1'b0, rts_n;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_port u_uart_port (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
    .cts_n(cts_n), .rts_n(rts_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic logic [10:0] mk(input logic [7:0] d, input bit l8, input bit pe,
                                     input bit odd, input bit badp, input bit stopv);
    logic [10:0] f = '1;
    int len = l8 ? 8 : 7;
    logic p = (^(l8 ? d : {1'b0, d[6:0]})) ^ odd ^ badp;
    f[0] = 1'b0;
    for (int i = 0; i < len; i++) f[1+i] = d[i];
    if (pe) f[1+len] = p;
    f[1+len+int'(pe)] = stopv;
    return f;
  endfunction

  task automatic send_rx(input logic [10:0] f, input int n, input int dv);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (16*dv - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic cap_tx(output logic [10:0] f, input int n, input int dv);
    int w = 0;
    f = '1;
    while (txd === 1'b1 && w < 2000) begin @(negedge clk); w++; end
    repeat (8*dv) @(negedge clk);
    f[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (16*dv) @(negedge clk);
      f[i] = txd;
    end
    repeat (16*dv) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] s;
    check("R1 txd idle", 32'(txd), 1);
    check("R1 rts_n", 32'(rts_n), 0);
    rd_reg(2'd3, s); check("R1 divisor", 32'(s), 0);
    rd_reg(2'd1, s); check("R1 status", 32'(s), 32'h2);
  endtask

  task automatic t_bit_time;
    int cnt = 0;
    wr_reg(2'd3, 16'd3); wr_reg(2'd2, 16'h1); wr_reg(2'd0, 16'hA5);
    while (txd === 1'b1) @(negedge clk);
    while (txd === 1'b0) begin cnt++; @(negedge clk); end
    check("R2 start bit length div3", 32'(cnt), 48);
    repeat (16*3*11) @(negedge clk);
  endtask

  task automatic t_tx_8e;
    logic [10:0] f;
    wr_reg(2'd3, 16'd1); wr_reg(2'd2, 16'h3); wr_reg(2'd0, 16'h3C);
    cap_tx(f, 11, 1);
    check("R4 R5 8E frame", 32'(f), 32'(mk(8'h3C, 1, 1, 0, 0, 1)));
  endtask

  task automatic t_tx_7o;
    logic [10:0] f;
    wr_reg(2'd2, 16'h6); wr_reg(2'd0, 16'h35);
    cap_tx(f, 10, 1);
    check("R4 R5 7O frame", 32'(f[9:0]), 32'h335 << 0 == 0 ? 0 : 32'(mk(8'h35, 0, 1, 1, 0, 1) & 11'h3FF));
  endtask

  task automatic t_rx_ok;
    logic [15:0] s;
    wr_reg(2'd2, 16'h3);
    send_rx(mk(8'h5A, 1, 1, 0, 0, 1), 11, 1);
    rd_reg(2'd1, s); check("R6 status full", 32'(s), 32'h3);
    rd_reg(2'd0, s); check("R6 data", 32'(s), 32'h5A);
    rd_reg(2'd1, s); check("R6 full cleared", 32'(s), 32'h2);
  endtask

  task automatic t_rx_parity;
    logic [15:0] s;
    send_rx(mk(8'h5A, 1, 1, 0, 1, 1), 11, 1);
    rd_reg(2'd1, s); check("R7 parity error", 32'(s), 32'h7);
    rd_reg(2'd0, s);
    rd_reg(2'd1, s); check("R13 flags cleared", 32'(s), 32'h2);
  endtask

  task automatic t_rx_frame;
    logic [15:0] s;
    send_rx(mk(8'h81, 1, 1, 0, 0, 0), 11, 1);
    rd_reg(2'd1, s); check("R8 framing error", 32'(s), 32'hB);
    rd_reg(2'd0, s); check("R8 data", 32'(s), 32'h81);
  endtask

  task automatic t_overrun;
    logic [15:0] s;
    send_rx(mk(8'h11, 1, 1, 0, 0, 1), 11, 1);
    send_rx(mk(8'h22, 1, 1, 0, 0, 1), 11, 1);
    rd_reg(2'd1, s); check("R9 overrun", 32'(s), 32'h13);
    rd_reg(2'd0, s); check("R9 first kept", 32'(s), 32'h11);
  endtask

  task automatic t_break;
    logic [15:0] s;
    @(negedge clk); rxd = 1'b0;
    repeat (16*12) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    rd_reg(2'd1, s); check("R10 break", 32'(s), 32'h2B);
    rd_reg(2'd0, s); check("R10 data zero", 32'(s), 0);
  endtask

  task automatic t_glitch;
    logic [15:0] s;
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (300) @(negedge clk);
    rd_reg(2'd1, s); check("R11 glitch ignored", 32'(s), 32'h2);
  endtask

  task automatic t_div0;
    logic [15:0] s;
    logic [10:0] f;
    int lows = 0;
    wr_reg(2'd3, 16'd0); wr_reg(2'd2, 16'h1); wr_reg(2'd0, 16'h55);
    repeat (400) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    check("R3 txd held high", 32'(lows), 0);
    send_rx(mk(8'h66, 1, 0, 0, 0, 1), 10, 1);
    rd_reg(2'd1, s); check("R3 nothing received, tx pending", 32'(s), 32'h0);
    wr_reg(2'd3, 16'd1);
    cap_tx(f, 10, 1);
    check("R3 resumes", 32'(f[9:0]), 32'(mk(8'h55, 1, 0, 0, 0, 1) & 11'h3FF));
  endtask

  task automatic t_handshake;
    logic [15:0] s;
    logic [10:0] f;
    int lows = 0;
    wr_reg(2'd2, 16'h9); cts_n = 1'b1;
    wr_reg(2'd0, 16'h77);
    repeat (300) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    check("R12 cts holds frame", 32'(lows), 0);
    cts_n = 1'b0;
    cap_tx(f, 10, 1);
    check("R12 frame after cts", 32'(f[9:0]), 32'(mk(8'h77, 1, 0, 0, 0, 1) & 11'h3FF));
    check("R12 rts_n empty", 32'(rts_n), 0);
    send_rx(mk(8'h12, 1, 0, 0, 0, 1), 10, 1);
    check("R12 rts_n full", 32'(rts_n), 1);
    rd_reg(2'd0, s);
    check("R12 rts_n after read", 32'(rts_n), 0);
    wr_reg(2'd2, 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bit_time();
    t_tx_8e();
    t_tx_7o();
    t_rx_ok();
    t_rx_parity();
    t_rx_frame();
    t_overrun();
    t_break();
    t_glitch();
    t_div0();
    t_handshake();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule